// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block lets a byte-wide memory of 2^13 locations answer on a two-wire (I2C) bus as a target device. The bus clock and data lines are sampled with the system clock through synchronizers, and start and stop conditions are recognised from the synchronized levels. The block frames bits into bytes and matches the device select byte. It collects a two-byte word address and drives an open-drain enable on the data line for acknowledges and read data.

A single address pointer is kept across transactions. It serves current-address reads, random reads (a write header with no data, followed by a repeated start), and sequential reads. Memory contents are read through a combinational read port that is addressed by the pointer. Each received write byte goes to a separate page-write unit as a one-cycle strobe with its address, and a commit strobe follows the stop. That unit's busy flag makes the engine silent while a write cycle is in progress.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the data-line enable is 0 (released) and the pointer reads 0, so a first current-address read returns the byte at address 0.
- R2: The first byte after a start is accepted only when its top four bits are 1010 and bits 3..1 equal the `dev_sel` strap. An accepted byte is acknowledged by driving the line low during the 9th clock. A byte that does not match gets no acknowledge, and the engine stays silent until the next start.
- R3: While `wr_busy` is high, no byte is acknowledged, including the device select byte with either value of bit 0.
- R4: With bit 0 of the select byte at 0, the next two bytes are the upper and lower halves of the word address, and each is acknowledged. The pointer becomes {upper[4:0], lower}. Upper bits 7..5 are ignored.
- R5: A write header with no data byte, followed by a repeated start, loads the pointer without producing any `wr_valid` or `wr_commit`.
- R6: With bit 0 of the select byte at 1, the byte at the pointer is sent MSB first. The pointer advances by one on the SCL fall that ends the 8th data bit, and it keeps its value between transactions.
- R7: After a read byte, an acknowledge from the controller makes the engine send the next byte. A missing acknowledge leaves the line released until the next start or stop.
- R8: A sequential read wraps the pointer from 0x1FFF to 0x0000.
- R9: Each complete write data byte raises `wr_valid` for one cycle, with `wr_addr` set to the pointer. Only pointer bits 4..0 then advance, wrapping inside the 32-byte page.
- R10: A stop after at least one complete data byte raises `wr_commit` for one cycle. A stop after only the address bytes, or a stop inside a partial data byte, produces no commit for the partial or missing byte.
- R11: A start at any bit position restarts framing at the device select byte. A stop at any point returns the engine to idle with the line released, and a stop during a read leaves the pointer as it was after the last completed byte.
- R12: The data-line enable rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel | input | 3 | Strap value compared with select byte bits 3..1 |
| rd_addr | output | 13 | Current pointer, used as memory read address |
| rd_data | input | 8 | Memory byte at `rd_addr` |
| wr_busy | input | 1 | Page-write unit is in a write cycle |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 13 | Address of the received write byte |
| wr_data | output | 8 | Received write byte |
| wr_commit | output | 1 | One-cycle strobe on a stop that ends a write with data |

## Verification
A wrong pointer shows up at `rd_addr` in the cycle after the lower address byte or after an 8th read-bit fall. It also appears in the first data bit of the next read, so the bench reads across a page boundary, across the top address, and through a stop in the middle of a read. A wrong framing state shows up within one byte as a missing or extra acknowledge. It also shows up as the line driven during a bit that belongs to the controller, and the bench watches the wired line on every 9th clock and after each restart. Errors in write handling appear at the `wr_valid` and `wr_commit` strobes within a cycle of the byte or stop that should cause them.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edge while clock held high on both samples
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ee_ptr.sv
module i2c_ee_ptr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_seq,
  input  logic              inc_page,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] AONE = 1;

  logic [ADDR_W-1:0] ptr_q, ptr_d, page_nxt;

  generate
    if (PAGE_W >= ADDR_W) begin : g_flat
      assign page_nxt = ptr_q + AONE;
    end else begin : g_paged
      localparam logic [PAGE_W-1:0] PONE = 1;
      assign page_nxt = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PONE};
    end
  endgenerate

  always_comb begin
    ptr_d = ptr_q;
    if (load)          ptr_d = load_val;
    else if (inc_seq)  ptr_d = ptr_q + AONE;
    else if (inc_page) ptr_d = page_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        dev_sel,
  input  logic              wr_busy,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] ptr_val,
  output logic              ptr_inc_seq,
  output logic              ptr_inc_page,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [3:0] LAST_BIT = 4'd8;

  ee_state_e       state, state_n;
  logic [3:0]      cnt, cnt_n;
  logic            in_ack, in_ack_n;
  logic [7:0]      sh, sh_n;
  logic [7:0]      tx, tx_n;
  logic [HI_W-1:0] hi_q, hi_n;
  logic            mack, mack_n;
  logic            got, got_n;
  logic            oe, oe_n;

  always_comb begin
    state_n      = state;
    cnt_n        = cnt;
    in_ack_n     = in_ack;
    sh_n         = sh;
    tx_n         = tx;
    hi_n         = hi_q;
    mack_n       = mack;
    got_n        = got;
    oe_n         = oe;
    ptr_load     = 1'b0;
    ptr_val      = {hi_q, sh};
    ptr_inc_seq  = 1'b0;
    ptr_inc_page = 1'b0;
    wr_valid     = 1'b0;
    wr_commit    = 1'b0;

    if (stop_det) begin
      wr_commit = (state == ST_WDAT) && got;
      state_n   = ST_IDLE;
      oe_n      = 1'b0;
      in_ack_n  = 1'b0;
      cnt_n     = '0;
      got_n     = 1'b0;
    end else if (start_det) begin
      state_n  = ST_DEV;
      oe_n     = 1'b0;
      in_ack_n = 1'b0;
      cnt_n    = '0;
      got_n    = 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (in_ack) begin
          // after the select ack this sees the engine's own low level
          mack_n = ~sda_s;
        end else if (cnt != LAST_BIT) begin
          sh_n  = {sh[6:0], sda_s};
          cnt_n = cnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack_n = 1'b0;
          cnt_n    = '0;
          oe_n     = 1'b0;
          if (state == ST_RDAT) begin
            if (mack) begin
              tx_n = rd_data;
              oe_n = ~rd_data[7];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end else if (cnt == LAST_BIT) begin
          in_ack_n = 1'b1;
          oe_n     = 1'b0;
          if (state == ST_RDAT) begin
            ptr_inc_seq = 1'b1;
          end else if (wr_busy) begin
            state_n  = ST_IDLE;
            in_ack_n = 1'b0;
          end else begin
            unique case (state)
              ST_DEV: begin
                if (sh[7:1] == {DEV_CODE, dev_sel}) begin
                  oe_n    = 1'b1;
                  state_n = sh[0] ? ST_RDAT : ST_AHI;
                end else begin
                  state_n  = ST_IDLE;
                  in_ack_n = 1'b0;
                end
              end
              ST_AHI: begin
                oe_n    = 1'b1;
                hi_n    = sh[HI_W-1:0];
                state_n = ST_ALO;
              end
              ST_ALO: begin
                oe_n     = 1'b1;
                ptr_load = 1'b1;
                state_n  = ST_WDAT;
              end
              ST_WDAT: begin
                oe_n         = 1'b1;
                wr_valid     = 1'b1;
                ptr_inc_page = 1'b1;
                got_n        = 1'b1;
              end
              default: state_n = ST_IDLE;
            endcase
          end
        end else if (state == ST_RDAT) begin
          oe_n = ~tx[3'd7 - cnt[2:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      in_ack <= 1'b0;
      sh     <= '0;
      tx     <= '0;
      hi_q   <= '0;
      mack   <= 1'b0;
      got    <= 1'b0;
      oe     <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      in_ack <= in_ack_n;
      sh     <= sh_n;
      tx     <= tx_n;
      hi_q   <= hi_n;
      mack   <= mack_n;
      got    <= got_n;
      oe     <= oe_n;
    end
  end

  assign sda_oe  = oe;
  assign wr_addr = ptr;
  assign wr_data = sh;
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic              wr_busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  logic [1:0]        rst_sh;
  logic              rst_ni;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ptr_load, ptr_inc_seq, ptr_inc_page;
  logic [ADDR_W-1:0] ptr_val, ptr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ni = rst_sh[1];

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_ee_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_ni),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_s        (sda_s),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .dev_sel      (dev_sel),
    .wr_busy      (wr_busy),
    .ptr          (ptr),
    .rd_data      (rd_data),
    .sda_oe       (sda_oe),
    .ptr_load     (ptr_load),
    .ptr_val      (ptr_val),
    .ptr_inc_seq  (ptr_inc_seq),
    .ptr_inc_page (ptr_inc_page),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .wr_commit    (wr_commit)
  );

  i2c_ee_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (ptr_load),
    .load_val (ptr_val),
    .inc_seq  (ptr_inc_seq),
    .inc_page (ptr_inc_page),
    .ptr      (ptr)
  );

  assign rd_addr = ptr;
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wr_busy,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] rd_addr
);
  localparam logic [PAGE_W-1:0] PONE = 1;

  logic [ADDR_W-1:0] page_step;
  assign page_step = {wr_addr[ADDR_W-1:PAGE_W], wr_addr[PAGE_W-1:0] + PONE};

  // R12: the engine starts pulling the line only while the clock is low
  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R3: no new drive while the page-write unit stays busy (no reads run then)
  p_busy_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && $past(wr_busy)) |-> !$rose(sda_oe));

  // R9: pointer steps within the page after each written byte
  p_page_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (rd_addr == $past(page_step)));

  // R10: commit is a single-cycle strobe and never overlaps a byte strobe
  p_commit_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  p_commit_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !wr_valid);

  // R11: line is released once a stop has ended a write
  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !sda_oe);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .wr_busy   (wr_busy),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .wr_commit (wr_commit),
  .rd_addr   (rd_addr)
);

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb;
  localparam int Q = 10;

  logic        clk, rst_n, scl, sda_c, sda_oe, wr_busy, wr_valid, wr_commit;
  logic [2:0]  dev_sel;
  logic [12:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;
  logic        sda_line;

  int total = 0, bad = 0, wv_cnt = 0, cm_cnt = 0, oe_viol = 0;
  logic [12:0] wv_a [0:7];
  logic [7:0]  wv_d [0:7];
  logic        oe_q;
  bit          done = 0;

  function automatic logic [7:0] memf(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  assign sda_line = sda_c & ~sda_oe;
  assign rd_data  = memf(rd_addr);

  i2c_eeprom_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .rd_addr(rd_addr), .rd_data(rd_data), .wr_busy(wr_busy),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    oe_q <= sda_oe;
    if (wr_valid) begin
      wv_a[wv_cnt[2:0]] <= wr_addr;
      wv_d[wv_cnt[2:0]] <= wr_data;
      wv_cnt <= wv_cnt + 1;
    end
    if (wr_commit) cm_cnt <= cm_cnt + 1;
    if (rst_n && sda_oe && !oe_q && scl) oe_viol <= oe_viol + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start;
    wq; sda_c = 1; wq; scl = 1; wq; sda_c = 0; wq; scl = 0;
  endtask

  task automatic i2c_stop;
    wq; sda_c = 0; wq; scl = 1; wq; sda_c = 1; wq; wq;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wq; sda_c = b[i]; wq; scl = 1; wq; wq; scl = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    wq; sda_c = 1; wq; scl = 1; wq; ack = !sda_line; wq; scl = 0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    wq; sda_c = 1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl = 1; wq; d[i] = sda_line; wq; scl = 0; wq;
    end
    sda_c = give_ack ? 1'b0 : 1'b1;
    wq; scl = 1; wq; wq; scl = 0;
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    logic a;
    i2c_start;
    send_byte(8'hA0, a); chk({tag, " sel ack"}, a, 1);
    send_byte(hi, a);    chk({tag, " hi ack R4"}, a, 1);
    send_byte(lo, a);    chk({tag, " lo ack R4"}, a, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // {expected ack, strap, select byte}; write direction only
  localparam logic [11:0] VEC [0:7] = '{
    12'h8A0, 12'h9A2, 12'hFAE, 12'h3A4, 12'h0B0, 12'h020, 12'hDAA, 12'h5AC
  };

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run;
  end

  initial begin
    logic       a;
    logic [7:0] d;
    int         c0, w0;
    scl = 1; sda_c = 1; wr_busy = 0; dev_sel = 3'd0; rst_n = 0;
    repeat (10) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 pointer after reset", rd_addr, 0);

    // R1/R6 current-address read from reset
    i2c_start;
    send_byte(8'hA1, a); chk("R2 read select ack", a, 1);
    recv_byte(0, d);     chk("R1 first read byte", d, memf(13'h0));
    i2c_stop;
    chk("R6 pointer advanced", rd_addr, 1);

    // R2 select table
    for (int i = 0; i < 8; i++) begin
      c0 = cm_cnt;
      dev_sel = VEC[i][10:8];
      i2c_start;
      send_byte(VEC[i][7:0], a);
      chk($sformatf("R2 select vec %0d", i), a, VEC[i][11]);
      i2c_stop;
      chk($sformatf("R10 no commit vec %0d", i), cm_cnt - c0, 0);
    end
    dev_sel = 3'd0;
    chk("R11 oe idle after table", sda_oe, 0);

    // R4/R5 dummy write then R7 sequential read
    w0 = wv_cnt; c0 = cm_cnt;
    set_ptr(8'hE3, 8'h45, "R5");
    chk("R4 pointer load with ignored bits", rd_addr, 13'h0345);
    i2c_start;
    send_byte(8'hA1, a); chk("R5 read after restart ack", a, 1);
    recv_byte(1, d); chk("R7 seq byte 0", d, memf(13'h0345));
    recv_byte(1, d); chk("R7 seq byte 1", d, memf(13'h0346));
    recv_byte(0, d); chk("R7 seq byte 2", d, memf(13'h0347));
    wq; chk("R7 released after nack", sda_oe, 0);
    i2c_stop;
    chk("R5 no write strobes", wv_cnt - w0, 0);
    chk("R5 no commit", cm_cnt - c0, 0);
    chk("R7 pointer after three", rd_addr, 13'h0348);

    // R6 pointer kept between transactions
    i2c_start;
    send_byte(8'hA1, a);
    recv_byte(0, d); chk("R6 current address read", d, memf(13'h0348));
    i2c_stop;

    // R8 wrap at top address
    set_ptr(8'h1F, 8'hFF, "R8");
    i2c_start;
    send_byte(8'hA1, a);
    recv_byte(1, d); chk("R8 last address", d, memf(13'h1FFF));
    recv_byte(0, d); chk("R8 wrapped to zero", d, memf(13'h0000));
    i2c_stop;
    chk("R8 pointer after wrap", rd_addr, 1);

    // R9/R10 page write crossing the page end
    w0 = wv_cnt; c0 = cm_cnt;
    set_ptr(8'h01, 8'h3E, "R9");
    send_byte(8'h11, a); chk("R9 data ack 0", a, 1);
    send_byte(8'h22, a); chk("R9 data ack 1", a, 1);
    send_byte(8'h33, a); chk("R9 data ack 2", a, 1);
    i2c_stop;
    chk("R9 strobe count", wv_cnt - w0, 3);
    chk("R9 addr 0", wv_a[w0[2:0]], 13'h013E);
    chk("R9 addr 1", wv_a[(w0 + 1) % 8], 13'h013F);
    chk("R9 addr 2 page wrap", wv_a[(w0 + 2) % 8], 13'h0120);
    chk("R9 data 2", wv_d[(w0 + 2) % 8], 8'h33);
    chk("R10 commit on stop", cm_cnt - c0, 1);
    chk("R9 pointer after write", rd_addr, 13'h0121);

    // R10 stop inside a partial byte
    w0 = wv_cnt; c0 = cm_cnt;
    set_ptr(8'h00, 8'h10, "R10");
    send_byte(8'h5A, a);
    send_bits(8'hC0, 3);
    i2c_stop;
    chk("R10 only full byte strobed", wv_cnt - w0, 1);
    chk("R10 full byte data", wv_d[w0[2:0]], 8'h5A);
    chk("R10 commit after partial", cm_cnt - c0, 1);

    // R3 busy: no ack, then ack once free
    wr_busy = 1;
    i2c_start;
    send_byte(8'hA1, a); chk("R3 no ack while busy (read)", a, 0);
    i2c_start;
    send_byte(8'hA0, a); chk("R3 no ack while busy (write)", a, 0);
    i2c_stop;
    wr_busy = 0;
    i2c_start;
    send_byte(8'hA1, a); chk("R3 ack after busy clears", a, 1);
    recv_byte(0, d);
    i2c_stop;

    // R11 restart in the middle of the select byte
    i2c_start;
    send_bits(8'hA0, 4);
    i2c_start;
    send_byte(8'hA0, a); chk("R11 restart reframes", a, 1);
    i2c_stop;

    // R11 stop during a read
    set_ptr(8'h00, 8'h7F, "R11");
    i2c_start;
    send_byte(8'hA1, a);
    recv_byte(1, d); chk("R11 byte before stop", d, memf(13'h007F));
    i2c_stop;
    chk("R11 released after stop", sda_oe, 0);
    chk("R11 pointer after aborted read", rd_addr, 13'h0080);
    i2c_start;
    send_byte(8'hA1, a);
    recv_byte(0, d); chk("R11 read resumes", d, memf(13'h0080));
    i2c_stop;

    chk("R12 drive starts only with clock low", oe_viol, 0);
    finish_run;
  end
endmodule